// File: doc/BRIEF.md
# Fractional Divider Frequency Step Controller

This block holds the numerator and denominator of a fractional feedback divider and nudges them with single pulses. A host loads a step word and a few control bits through a byte-wide write port. Each rising edge on the increment or decrement input then adds the step word to the selected divider value, or subtracts it. The updated value appears on parallel outputs together with a one-cycle strobe, which the divider datapath can use to take the new value.

The step word is an unsigned magnitude. The direction of a change comes only from the pulse that arrived. The target is chosen so that an increment always raises the output frequency: it raises the numerator or lowers the denominator. Updates are blocked while the mask bit is set or while fractional mode is off. The arithmetic saturates at both ends of the 56-bit range instead of wrapping.

Top module: `fstep_ctrl`

## Requirements
- R1: After a synchronous reset, num_o equals NUM_RST and den_o equals DEN_RST. upd_o is 0, the mask bit is 0, the target bit is 0, fractional mode is off and the step word is 0.
- R2: The step word is written as seven bytes at addresses 1 to 7, with the least significant byte at address 1. The control register is at address 0: bit 0 is the mask, bit 1 selects the denominator as target (0 selects the numerator), and bit 2 is the fractional enable.
- R3: With the numerator as target, an increment pulse adds the step word to num_o and a decrement pulse subtracts it.
- R4: With the denominator as target, an increment pulse subtracts the step word from den_o and a decrement pulse adds it.
- R5: While the mask bit is 1, pulses change neither output value and raise no strobe.
- R6: While the fractional enable is 0, pulses change neither output value and raise no strobe.
- R7: Each rising edge of an input causes exactly one update. Holding the input high causes no further updates.
- R8: If increment and decrement rise in the same cycle, no update is made.
- R9: An addition that would pass 2^56-1 gives all ones, and a subtraction that would go below zero gives zero.
- R10: upd_o is high for one cycle, on the cycle after the clock edge that samples the pulse. In that same cycle the new value is on the output. The value that was not targeted stays unchanged.
- R11: Host writes to the numerator bytes (addresses 8 to 14) or the denominator bytes (addresses 15 to 21) are stored least significant byte first. Such a write drops a step pulse in the same cycle, and no strobe is raised for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| inc_i | input | 1 | Frequency increment request, acted on at its rising edge |
| dec_i | input | 1 | Frequency decrement request, acted on at its rising edge |
| num_o | output | 56 | Divider numerator |
| den_o | output | 56 | Divider denominator |
| upd_o | output | 1 | One-cycle strobe marking a step update |

## Verification
On every cycle the assertions check several properties. Pulses arriving while the block is masked, in integer mode, while both inputs rise together, or while a host divider write is in progress never produce a strobe. An edge detector never reports two rises in a row. Saturated results never move the wrong way. An increment never lowers the numerator or raises the denominator, and a strobe leaves the untargeted value unchanged. Only the bench scenarios can show the exact sums and differences, the byte order of the step word and of the divider values, the fact that a level held high updates only once, and the exact values at which saturation stops.

// File: rtl/fstep_pkg.sv
package fstep_pkg;
    localparam int STEP_W   = 56;
    localparam int NBYTES   = STEP_W / 8;
    localparam int CTRL_ADR = 0;
    localparam int STEP_ADR = 1;
    localparam int NUM_ADR  = STEP_ADR + NBYTES;
    localparam int DEN_ADR  = NUM_ADR + NBYTES;

    typedef struct packed {
        logic              mask;
        logic              tgt_den;
        logic              frac_en;
        logic [STEP_W-1:0] step;
        logic [STEP_W-1:0] num;
        logic [STEP_W-1:0] den;
        logic              upd;
    } fstep_state_t;
endpackage

// File: rtl/fstep_edge_det.sv
module fstep_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= prev_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_RISE_ONCE: assert property (@(posedge clk) disable iff (rst)
            rise_o[g] |=> !rise_o[g]); // R7
    end
endmodule

// File: rtl/fstep_sat_arith.sv
module fstep_sat_arith #(
    parameter int W = 56
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         add_i,
    output logic [W-1:0] res_o
);
    logic [W:0] sum_d;

    always_comb begin
        sum_d = {1'b0, a_i} + {1'b0, b_i};
        if (add_i) res_o = sum_d[W] ? {W{1'b1}} : sum_d[W-1:0];
        else       res_o = (b_i > a_i) ? '0 : a_i - b_i;
    end

    always_comb begin
        if (add_i) begin
            AST_SAT_ADD: assert (res_o >= a_i); // R9
        end else begin
            AST_SAT_SUB: assert (res_o <= a_i); // R9
        end
    end
endmodule

// File: rtl/fstep_ctrl.sv
module fstep_ctrl
    import fstep_pkg::*;
#(
    parameter int                ADDR_W  = 5,
    parameter logic [STEP_W-1:0] NUM_RST = STEP_W'(1000),
    parameter logic [STEP_W-1:0] DEN_RST = STEP_W'(2000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              inc_i,
    input  logic              dec_i,
    output logic [STEP_W-1:0] num_o,
    output logic [STEP_W-1:0] den_o,
    output logic              upd_o
);
    fstep_state_t      s_d, s_q;
    logic [1:0]        rise;
    logic              inc_rise, dec_rise;
    logic              div_wr_d;
    logic              fire_d;
    logic              add_d;
    logic [STEP_W-1:0] opnd_d, res_d;
    logic              tgt_den_q;

    fstep_edge_det #(.N(2)) i_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  ({dec_i, inc_i}),
        .rise_o (rise)
    );

    assign inc_rise  = rise[0];
    assign dec_rise  = rise[1];
    assign tgt_den_q = s_q.tgt_den;

    always_comb begin
        opnd_d = s_q.tgt_den ? s_q.den : s_q.num;
        add_d  = s_q.tgt_den ? dec_rise : inc_rise;
    end

    fstep_sat_arith #(.W(STEP_W)) i_arith (
        .a_i   (opnd_d),
        .b_i   (s_q.step),
        .add_i (add_d),
        .res_o (res_d)
    );

    always_comb begin
        s_d      = s_q;
        s_d.upd  = 1'b0;
        div_wr_d = 1'b0;
        if (wr_en_i) begin
            if (wr_addr_i == ADDR_W'(CTRL_ADR)) begin
                s_d.mask    = wr_data_i[0];
                s_d.tgt_den = wr_data_i[1];
                s_d.frac_en = wr_data_i[2];
            end
            for (int i = 0; i < NBYTES; i++) begin
                if (wr_addr_i == ADDR_W'(STEP_ADR + i)) s_d.step[8*i +: 8] = wr_data_i;
                if (wr_addr_i == ADDR_W'(NUM_ADR + i)) begin
                    s_d.num[8*i +: 8] = wr_data_i;
                    div_wr_d          = 1'b1;
                end
                if (wr_addr_i == ADDR_W'(DEN_ADR + i)) begin
                    s_d.den[8*i +: 8] = wr_data_i;
                    div_wr_d          = 1'b1;
                end
            end
        end
        fire_d = (inc_rise ^ dec_rise) && !s_q.mask && s_q.frac_en && !div_wr_d;
        if (fire_d) begin
            if (s_q.tgt_den) s_d.den = res_d;
            else             s_d.num = res_d;
            s_d.upd = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.mask    <= 1'b0;
            s_q.tgt_den <= 1'b0;
            s_q.frac_en <= 1'b0;
            s_q.step    <= '0;
            s_q.num     <= NUM_RST;
            s_q.den     <= DEN_RST;
            s_q.upd     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign num_o = s_q.num;
    assign den_o = s_q.den;
    assign upd_o = s_q.upd;

    AST_MASK_NO_UPD: assert property (@(posedge clk) disable iff (rst)
        s_q.mask |=> !upd_o); // R5
    AST_INT_NO_UPD: assert property (@(posedge clk) disable iff (rst)
        !s_q.frac_en |=> !upd_o); // R6
    AST_BOTH_NO_UPD: assert property (@(posedge clk) disable iff (rst)
        (inc_rise && dec_rise) |=> !upd_o); // R8
    AST_HOST_WINS: assert property (@(posedge clk) disable iff (rst)
        div_wr_d |=> !upd_o); // R11
    AST_NUM_INC_UP: assert property (@(posedge clk) disable iff (rst)
        (!tgt_den_q && inc_rise) |=> (!upd_o || num_o >= $past(num_o))); // R3
    AST_DEN_INC_DOWN: assert property (@(posedge clk) disable iff (rst)
        (tgt_den_q && inc_rise) |=> (!upd_o || den_o <= $past(den_o))); // R4
    AST_OTHER_HELD: assert property (@(posedge clk) disable iff (rst)
        (!div_wr_d && !wr_en_i) |=> (!upd_o || ($past(tgt_den_q) ? $stable(num_o) : $stable(den_o)))); // R10
endmodule

// File: tb/test_fstep_ctrl.sv
module test_fstep_ctrl;
    localparam int W = 56;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_addr = '0;
    logic [7:0]   wr_data = '0;
    logic         inc = 1'b0;
    logic         dec = 1'b0;
    logic [W-1:0] num, den;
    logic         upd;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [W-1:0] s_num, s_den;
    logic         s_upd;

    always #2.5 clk = ~clk;

    fstep_ctrl i_fstep_ctrl (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .inc_i(inc), .dec_i(dec), .num_o(num), .den_o(den), .upd_o(upd)
    );

    typedef struct packed {
        logic [7:0]   ctrl;
        logic         up;
        logic [W-1:0] e_num;
        logic [W-1:0] e_den;
        logic         e_upd;
    } vec_t;

    // ctrl bits: [0] mask, [1] denominator target, [2] fractional enable; step = 10
    localparam vec_t VECS [8] = '{
        '{8'h04, 1'b1, 56'd1010, 56'd2000, 1'b1},
        '{8'h04, 1'b0, 56'd1000, 56'd2000, 1'b1},
        '{8'h04, 1'b0, 56'd990,  56'd2000, 1'b1},
        '{8'h06, 1'b1, 56'd990,  56'd1990, 1'b1},
        '{8'h06, 1'b0, 56'd990,  56'd2000, 1'b1},
        '{8'h06, 1'b0, 56'd990,  56'd2010, 1'b1},
        '{8'h05, 1'b1, 56'd990,  56'd2010, 1'b0},
        '{8'h00, 1'b1, 56'd990,  56'd2010, 1'b0}
    };

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr56(input logic [4:0] base, input logic [W-1:0] v);
        for (int i = 0; i < 7; i++) wr(base + 5'(i), v[8*i +: 8]);
    endtask

    task automatic pulse(input bit up);
        @(negedge clk);
        inc = up; dec = !up;
        @(negedge clk);
        s_num = num; s_den = den; s_upd = upd;
        inc = 1'b0; dec = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 num reset", num, 56'd1000);
        chk("R1 den reset", den, 56'd2000);
        chk("R1 upd reset", W'(upd), 0);
        // R1: fractional mode is off after reset, so a pulse is ignored
        pulse(1'b1);
        chk("R1 frac off at reset", W'(s_upd), 0);
        // R1: the step word is zero after reset
        wr(5'd0, 8'h04);
        pulse(1'b1);
        chk("R1 zero step upd", W'(s_upd), 1);
        chk("R1 zero step num", s_num, 56'd1000);
        wr56(5'd1, 56'd10);
        for (int k = 0; k < 8; k++) begin
            wr(5'd0, VECS[k].ctrl);
            pulse(VECS[k].up);
            chk($sformatf("R3/R4/R5/R6 vec%0d num", k), s_num, VECS[k].e_num);
            chk($sformatf("R3/R4/R5/R6 vec%0d den", k), s_den, VECS[k].e_den);
            chk($sformatf("R10 vec%0d upd", k), W'(s_upd), W'(VECS[k].e_upd));
        end
        // R7: level held high updates once
        wr(5'd0, 8'h04);
        @(negedge clk); inc = 1'b1;
        @(negedge clk);
        chk("R7 first edge num", num, 56'd1000);
        chk("R10 strobe on edge", W'(upd), 1);
        repeat (2) @(negedge clk);
        chk("R7 held no repeat num", num, 56'd1000);
        chk("R10 strobe single", W'(upd), 0);
        inc = 1'b0;
        @(negedge clk);
        // R8: both rise together
        @(negedge clk); inc = 1'b1; dec = 1'b1;
        @(negedge clk);
        chk("R8 both num", num, 56'd1000);
        chk("R8 both upd", W'(upd), 0);
        inc = 1'b0; dec = 1'b0;
        @(negedge clk);
        // R11: host write wins over a step in the same cycle
        wr56(5'd8, 56'd0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd8; wr_data = 8'h55; inc = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; inc = 1'b0;
        chk("R11 host wins num", num, 56'h55);
        chk("R11 no strobe", W'(upd), 0);
        @(negedge clk);
        // R9: saturation
        wr56(5'd8, 56'hFFFFFFFFFFFFFA);
        pulse(1'b1);
        chk("R9 add saturates", s_num, 56'hFFFFFFFFFFFFFF);
        wr56(5'd8, 56'd3);
        pulse(1'b0);
        chk("R9 sub saturates", s_num, 56'd0);
        // R2: multi-byte step word byte order
        wr56(5'd1, 56'h01000000000001);
        wr56(5'd8, 56'd0);
        pulse(1'b1);
        chk("R2 step bytes num", s_num, 56'h01000000000001);
        chk("R10 other held den", s_den, 56'd2010);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule